// File: doc/BRIEF.md
# Shared-Bus SPI Master with Open-Drain Arbitration

This block is an SPI master that shares one SPI memory with a second, independent master. The two masters coordinate through one open-drain "bus in use" line, pulled high when nobody holds it, and by watching the shared chip-select. Local user logic asks for a transfer of N bytes and supplies the transmit bytes as a valid/ready stream. Each received byte comes back with a one-cycle valid strobe.

To take the bus, the block first waits until the synchronized arbitration line reads high. It then pulls the line low and lets a guard interval of `GUARD_CYCLES` clocks run out. At the end of the guard it checks the shared chip-select. If the chip-select is still high, the block owns the bus and runs a mode-0, MSB-first transfer with SCLK at `clk / (2*HALF_DIV)`.

If the chip-select is already low at the end of the guard, the block lets go of its claim. It then waits a pseudo-random back-off taken from an LFSR and tries again. After `MAX_TRIES` lost attempts it ends the request with the lost status set. Every shared line is given as an output-enable plus a value, so the system, or a bench with pull-ups, resolves the wired bus. When the block does not own the bus it drives nothing except, while claiming, the arbitration line held low.

Top module: `spi_shared_master`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, tx_ready_o, rx_valid_o and every output-enable (arb_oe_o, cs_oe_o, sclk_oe_o, mosi_oe_o) are 0.
- R2: A claim (arb_oe_o rising) happens only after the arbitration line, passed through a two-flop synchronizer, reads high. While another agent holds the line low, arb_oe_o stays 0.
- R3: From the clock on which arb_oe_o rises to the clock on which cs_oe_o rises, exactly GUARD_CYCLES clocks pass.
- R4: If the synchronized shared chip-select is low at the end of the guard, the block drops arb_oe_o without ever enabling CS, SCLK or MOSI. It backs off for 1 to 2^LFSR_W-1 clocks, waits for the line to be free again and retries. If a later try succeeds, done_o comes with lost_o = 0.
- R5: When MAX_TRIES attempts in a row are lost, done_o pulses with lost_o = 1 and no SPI transfer takes place.
- R6: Whenever arb_oe_o is 0, cs_oe_o, sclk_oe_o and mosi_oe_o are all 0.
- R7: The transfer is SPI mode 0. SCLK idles low, MOSI changes after falling edges, and each byte goes out MSB first, in the order the bytes were accepted on the tx stream.
- R8: MISO is sampled on the rising SCLK edges, MSB first. Each completed byte is presented on rx_data_o with a one-cycle rx_valid_o, while CS is driven low.
- R9: CS goes low at least HALF_DIV clocks before the first rising SCLK edge. It is driven high at least HALF_DIV clocks after the last falling edge, before the lines are released.
- R10: At the end of a transfer, CS, SCLK, MOSI and the arbitration line are released in the same clock as the one-cycle done_o pulse, and busy_o falls with it.
- R11: A start with nbytes_i = 0 produces done_o one clock later with lost_o = 0. The block makes no claim.
- R12: While the block waits for a transmit byte (tx_ready_o = 1), SCLK is held low, so a stalled stream produces no clock edges and no wrong data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a transfer (sampled while idle) |
| nbytes_i | input | COUNT_W | Number of bytes to transfer |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| lost_o | output | 1 | With done_o: arbitration lost MAX_TRIES times |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte valid |
| tx_ready_o | output | 1 | Block accepts a transmit byte |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |
| arb_i | input | 1 | Resolved level of the shared arbitration line |
| arb_oe_o | output | 1 | 1 pulls the arbitration line low |
| cs_i | input | 1 | Resolved level of the shared chip-select |
| cs_oe_o | output | 1 | Chip-select output-enable |
| cs_o | output | 1 | Chip-select driven value |
| sclk_oe_o | output | 1 | SCLK output-enable |
| sclk_o | output | 1 | SCLK driven value |
| mosi_oe_o | output | 1 | MOSI output-enable |
| mosi_o | output | 1 | MOSI driven value |
| miso_i | input | 1 | Data from the memory |

## Verification
The hardest case to reach from the ports is a collision: both masters pull the arbitration line low in the same window, and the peer wins by lowering chip-select before this block's guard runs out. The bench contains a peer model that watches arb_oe_o. In the cycle the claim appears, the peer seizes both the arbitration line and chip-select and holds them for a while. This forces a loss, a back-off, a wait on the busy line and a second, successful claim. A peer that holds chip-select low without ever claiming drives the block through every retry to the lost status.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    T_IDLE, T_WAIT, T_GUARD, T_BACK, T_XFER, T_REL
  } arb_state_t;

  typedef enum logic [2:0] {
    E_IDLE, E_LOAD, E_LO, E_HI, E_TRAIL
  } eng_state_t;
endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, q_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      q_q    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_q    <= meta_q;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/spim_lfsr.sv
module spim_lfsr #(
  parameter int W = 5,
  parameter logic [W-1:0] TAPS = 5'b10100,
  parameter logic [W-1:0] SEED = 5'b00001
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] val_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign val_o = q;
endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; #(
  parameter int HALF_DIV = 2,
  parameter int COUNT_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go_i,
  input  logic [COUNT_W-1:0] nbytes_i,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic               miso_i,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic [7:0]         rx_data_o,
  output logic               rx_valid_o,
  output logic               fin_o
);
  localparam int HW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);
  localparam logic [HW-1:0] HRELOAD = HW'(HALF_DIV - 1);

  eng_state_t         st;
  logic [HW-1:0]      hc;
  logic [2:0]         bitn;
  logic [7:0]         txsh, rxsh;
  logic [COUNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= E_IDLE; hc <= '0; bitn <= '0; txsh <= '0; rxsh <= '0;
      left <= '0; sclk_o <= 1'b0; mosi_o <= 1'b0;
      rx_data_o <= '0; rx_valid_o <= 1'b0; fin_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      fin_o      <= 1'b0;
      case (st)
        E_IDLE: if (go_i) begin
          left   <= nbytes_i;
          sclk_o <= 1'b0;
          st     <= E_LOAD;
        end
        E_LOAD: if (tx_valid_i) begin
          txsh   <= tx_data_i;
          mosi_o <= tx_data_i[7];
          bitn   <= 3'd7;
          hc     <= HRELOAD;
          st     <= E_LO;
        end
        E_LO: begin
          if (hc == '0) begin
            sclk_o <= 1'b1;
            rxsh   <= {rxsh[6:0], miso_i};
            hc     <= HRELOAD;
            st     <= E_HI;
          end else hc <= hc - HW'(1);
        end
        E_HI: begin
          if (hc == '0) begin
            sclk_o <= 1'b0;
            hc     <= HRELOAD;
            if (bitn == 3'd0) begin
              rx_data_o  <= rxsh;
              rx_valid_o <= 1'b1;
              left       <= left - COUNT_W'(1);
              st         <= (left == COUNT_W'(1)) ? E_TRAIL : E_LOAD;
            end else begin
              bitn   <= bitn - 3'd1;
              txsh   <= {txsh[6:0], 1'b0};
              mosi_o <= txsh[6];
              st     <= E_LO;
            end
          end else hc <= hc - HW'(1);
        end
        E_TRAIL: begin
          if (hc == '0) begin
            fin_o <= 1'b1;
            st    <= E_IDLE;
          end else hc <= hc - HW'(1);
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign tx_ready_o = (st == E_LOAD);
endmodule

// File: rtl/spi_shared_master.sv
module spi_shared_master import spim_pkg::*; #(
  parameter int GUARD_CYCLES = 8,
  parameter int HALF_DIV     = 2,
  parameter int MAX_TRIES    = 3,
  parameter int COUNT_W      = 8,
  parameter int LFSR_W       = 5,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 5'b10100,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 5'b00001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [COUNT_W-1:0] nbytes_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               lost_o,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  output logic [7:0]         rx_data_o,
  output logic               rx_valid_o,
  input  logic               arb_i,
  output logic               arb_oe_o,
  input  logic               cs_i,
  output logic               cs_oe_o,
  output logic               cs_o,
  output logic               sclk_oe_o,
  output logic               sclk_o,
  output logic               mosi_oe_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int GW = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES);
  localparam int TW = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);

  arb_state_t         st;
  logic               arb_free, cs_idle;
  logic [GW-1:0]      gcnt;
  logic [TW-1:0]      tries;
  logic [LFSR_W-1:0]  bcnt, rnd;
  logic [COUNT_W-1:0] nb_q;
  logic               arb_oe_q, own_q, cs_q, busy_q, done_q, lost_q, eng_go;
  logic               eng_sclk, eng_mosi, eng_fin;

  spim_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d_i({arb_i, cs_i}), .q_o({arb_free, cs_idle})
  );

  spim_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .val_o(rnd)
  );

  spim_engine #(.HALF_DIV(HALF_DIV), .COUNT_W(COUNT_W)) u_eng (
    .clk(clk), .rst(rst), .go_i(eng_go), .nbytes_i(nb_q),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .miso_i(miso_i), .sclk_o(eng_sclk), .mosi_o(eng_mosi),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .fin_o(eng_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; gcnt <= '0; tries <= '0; bcnt <= '0; nb_q <= '0;
      arb_oe_q <= 1'b0; own_q <= 1'b0; cs_q <= 1'b1; busy_q <= 1'b0;
      done_q <= 1'b0; lost_q <= 1'b0; eng_go <= 1'b0;
    end else begin
      done_q <= 1'b0;
      eng_go <= 1'b0;
      case (st)
        T_IDLE: if (start_i) begin
          lost_q <= 1'b0;
          tries  <= '0;
          if (nbytes_i == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            nb_q   <= nbytes_i;
            st     <= T_WAIT;
          end
        end
        T_WAIT: if (arb_free) begin
          arb_oe_q <= 1'b1;
          gcnt     <= GW'(GUARD_CYCLES - 1);
          st       <= T_GUARD;
        end
        T_GUARD: begin
          if (gcnt != '0) begin
            gcnt <= gcnt - GW'(1);
          end else if (!cs_idle) begin
            arb_oe_q <= 1'b0;
            if (tries == TW'(MAX_TRIES - 1)) begin
              lost_q <= 1'b1;
              done_q <= 1'b1;
              busy_q <= 1'b0;
              st     <= T_IDLE;
            end else begin
              tries <= tries + TW'(1);
              bcnt  <= rnd;
              st    <= T_BACK;
            end
          end else begin
            own_q  <= 1'b1;
            cs_q   <= 1'b0;
            eng_go <= 1'b1;
            st     <= T_XFER;
          end
        end
        T_BACK: begin
          if (bcnt == '0) st <= T_WAIT;
          else            bcnt <= bcnt - LFSR_W'(1);
        end
        T_XFER: if (eng_fin) begin
          cs_q <= 1'b1;
          st   <= T_REL;
        end
        T_REL: begin
          own_q    <= 1'b0;
          arb_oe_q <= 1'b0;
          done_q   <= 1'b1;
          busy_q   <= 1'b0;
          st       <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign lost_o    = lost_q;
  assign arb_oe_o  = arb_oe_q;
  assign cs_oe_o   = own_q;
  assign cs_o      = cs_q;
  assign sclk_oe_o = own_q;
  assign sclk_o    = eng_sclk;
  assign mosi_oe_o = own_q;
  assign mosi_o    = eng_mosi;
endmodule

// File: rtl/spi_shared_master_chk.sv
module spi_shared_master_chk #(
  parameter int GUARD_CYCLES = 8
) (
  input logic clk,
  input logic rst,
  input logic arb_free,
  input logic arb_oe_o,
  input logic cs_oe_o,
  input logic cs_o,
  input logic sclk_oe_o,
  input logic sclk_o,
  input logic mosi_oe_o,
  input logic tx_ready_o,
  input logic rx_valid_o,
  input logic done_o,
  input logic busy_o
);
  int gcnt;

  always_ff @(posedge clk) begin
    if (rst || !arb_oe_o) gcnt <= 0;
    else if (!cs_oe_o)    gcnt <= gcnt + 1;
  end

  p_tristate_r6: assert property (@(posedge clk) disable iff (rst)
    !arb_oe_o |-> (!cs_oe_o && !sclk_oe_o && !mosi_oe_o));

  p_claim_free_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_oe_o) |-> $past(arb_free));

  p_guard_len_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_oe_o) |-> (gcnt == GUARD_CYCLES));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!arb_oe_o && !cs_oe_o && !busy_o));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_rx_in_frame_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> (cs_oe_o && !cs_o));

  p_stall_no_clk_r12: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |-> !sclk_o);

  p_cs_low_clk_r9: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe_o && sclk_o) |-> !cs_o);
endmodule

bind spi_shared_master spi_shared_master_chk #(.GUARD_CYCLES(GUARD_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .arb_free(arb_free), .arb_oe_o(arb_oe_o),
  .cs_oe_o(cs_oe_o), .cs_o(cs_o), .sclk_oe_o(sclk_oe_o), .sclk_o(sclk_o),
  .mosi_oe_o(mosi_oe_o), .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o),
  .done_o(done_o), .busy_o(busy_o)
);

// File: tb/spi_shared_master_bench.sv
`timescale 1ns/1ps
module spi_shared_master_bench;
  localparam int GUARD = 8;
  localparam int HALF  = 2;
  localparam int TRIES = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       start = 1'b0;
  logic [7:0] nbytes = '0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       busy, done, lost, tx_ready, rx_valid;
  logic [7:0] rx_data;
  logic       arb_oe, cs_oe, cs_v, sclk_oe, sclk_v, mosi_oe, mosi_v;
  logic       peer_arb = 1'b0, peer_cs = 1'b0;
  logic [7:0] s_tx = '0;

  wire arb_bus  = !(arb_oe || peer_arb);
  wire cs_bus   = cs_oe ? cs_v : !peer_cs;
  wire sclk_bus = sclk_oe ? sclk_v : 1'b1;
  wire mosi_bus = mosi_oe ? mosi_v : 1'b1;
  wire miso_bus = cs_bus ? 1'b1 : s_tx[7];

  spi_shared_master #(.GUARD_CYCLES(GUARD), .HALF_DIV(HALF), .MAX_TRIES(TRIES)) u_spi_shared_master (
    .clk(clk), .rst(rst), .start_i(start), .nbytes_i(nbytes), .busy_o(busy),
    .done_o(done), .lost_o(lost), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .arb_i(arb_bus), .arb_oe_o(arb_oe), .cs_i(cs_bus), .cs_oe_o(cs_oe), .cs_o(cs_v),
    .sclk_oe_o(sclk_oe), .sclk_o(sclk_v), .mosi_oe_o(mosi_oe), .mosi_o(mosi_v),
    .miso_i(miso_bus)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // transfer plan and captured traffic
  logic [7:0] tx_plan [4];
  logic [7:0] rep_plan [4];
  int n_plan = 0, tx_idx = 0, stall_len = 0, stall_cnt = 0;
  logic [7:0] mosi_q [$];
  logic [7:0] rx_q [$];

  // SPI memory model (mode 0)
  int s_bits = 0, rep_idx = 0;
  logic [7:0] s_rx = '0;
  always @(negedge cs_bus) begin
    s_tx = rep_plan[0]; rep_idx = 1; s_bits = 0;
  end
  always @(posedge sclk_bus) if (!cs_bus) begin
    s_rx = {s_rx[6:0], mosi_bus};
    s_bits++;
    if (s_bits == 8) mosi_q.push_back(s_rx);
  end
  always @(negedge sclk_bus) if (!cs_bus && s_bits > 0) begin
    if (s_bits == 8) begin
      s_tx = (rep_idx < 4) ? rep_plan[rep_idx] : 8'h00;
      rep_idx++; s_bits = 0;
    end else s_tx = {s_tx[6:0], 1'b0};
  end

  // per-cycle monitor, tx driver, peer model
  bit prev_arb = 0, prev_own = 0, prev_sck = 0, prev_csd = 0;
  int claim_cyc = 0, claims = 0, losses = 0, own_rises = 0;
  int csf_cyc = 0, lastf_cyc = 0, first_edge = 0;
  bit collide_arm = 0;
  int peer_hold = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      chk(0, "WD", "watchdog expired", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) if (!rst) begin
    if (!arb_oe) chk(!cs_oe && !sclk_oe && !mosi_oe, "R6", "lines driven without claim",
                     {cs_oe, sclk_oe, mosi_oe}, 0);
    if (tx_ready) chk(cs_oe && !sclk_v, "R12", "sclk high while waiting for byte", sclk_v, 0);
    if (arb_oe && !prev_arb) begin claims++; claim_cyc = cyc; end
    if (!arb_oe && prev_arb && !prev_own) losses++;
    if (cs_oe && !prev_own) begin
      own_rises++;
      chk(cyc - claim_cyc == GUARD, "R3", "guard length", cyc - claim_cyc, GUARD);
    end
    if (cs_oe && !cs_v && !prev_csd) begin csf_cyc = cyc; first_edge = 1; end
    if (cs_oe && sclk_v && !prev_sck && first_edge) begin
      chk(cyc - csf_cyc >= HALF, "R9", "cs lead", cyc - csf_cyc, HALF);
      first_edge = 0;
    end
    if (cs_oe && !sclk_v && prev_sck) lastf_cyc = cyc;
    if (cs_oe && cs_v && prev_csd)
      chk(cyc - lastf_cyc >= HALF, "R9", "cs trail", cyc - lastf_cyc, HALF);
    if (rx_valid) rx_q.push_back(rx_data);
    prev_arb = arb_oe; prev_own = cs_oe; prev_sck = cs_oe && sclk_v; prev_csd = cs_oe && !cs_v;
    // tx stream
    if (tx_valid) begin tx_idx++; tx_valid = 0; stall_cnt = stall_len; end
    if (tx_ready && tx_idx < n_plan) begin
      if (stall_cnt > 0) stall_cnt--;
      else begin tx_valid = 1; tx_data = tx_plan[tx_idx]; end
    end
    // colliding peer
    if (collide_arm && arb_oe) begin
      peer_arb = 1; peer_cs = 1; collide_arm = 0; peer_hold = 40;
    end else if (peer_hold > 0) begin
      peer_hold--;
      if (peer_hold == 0) begin peer_arb = 0; peer_cs = 0; end
    end
  end

  bit got_lost;
  task automatic run_req(input int n, input int stall);
    int waitc;
    n_plan = n; tx_idx = 0; stall_len = stall; stall_cnt = stall;
    mosi_q.delete(); rx_q.delete(); claims = 0; losses = 0; own_rises = 0;
    @(negedge clk); start = 1; nbytes = 8'(n);
    @(negedge clk); start = 0;
    waitc = 0;
    while (!done && waitc < 5000) begin @(negedge clk); waitc++; end
    chk(done, "R10", "done seen", done, 1);
    got_lost = lost;
    chk(!busy && !arb_oe && !cs_oe && !sclk_oe && !mosi_oe, "R10", "release with done",
        {busy, arb_oe, cs_oe, sclk_oe, mosi_oe}, 0);
    @(negedge clk);
    chk(!done, "R10", "done is one pulse", done, 0);
  endtask

  task automatic check_data(input int n);
    chk(mosi_q.size() == n, "R7", "mosi byte count", mosi_q.size(), n);
    chk(rx_q.size() == n, "R8", "rx byte count", rx_q.size(), n);
    for (int i = 0; i < n; i++) begin
      if (i < mosi_q.size()) chk(mosi_q[i] == tx_plan[i], "R7", "mosi byte", mosi_q[i], tx_plan[i]);
      if (i < rx_q.size())   chk(rx_q[i] == rep_plan[i], "R8", "rx byte", rx_q[i], rep_plan[i]);
    end
  endtask

  initial begin
    tx_plan  = '{8'hA5, 8'h3C, 8'h81, 8'h7E};
    rep_plan = '{8'h5A, 8'hC3, 8'h18, 8'hE7};
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!busy && !done && !tx_ready && !rx_valid, "R1", "status after reset",
        {busy, done, tx_ready, rx_valid}, 0);
    chk(!arb_oe && !cs_oe && !sclk_oe && !mosi_oe, "R1", "enables after reset",
        {arb_oe, cs_oe, sclk_oe, mosi_oe}, 0);

    // basic two-byte transfer
    run_req(2, 0);
    chk(!got_lost, "R10", "lost flag on clean win", got_lost, 0);
    check_data(2);

    // line held by another agent: no claim until free
    peer_arb = 1;
    n_plan = 1; tx_idx = 0; stall_len = 0; stall_cnt = 0;
    mosi_q.delete(); rx_q.delete(); claims = 0;
    @(negedge clk); start = 1; nbytes = 8'd1;
    @(negedge clk); start = 0;
    repeat (30) @(negedge clk);
    chk(claims == 0 && !arb_oe, "R2", "claims while line busy", claims, 0);
    peer_arb = 0;
    begin
      int w = 0;
      while (!done && w < 5000) begin @(negedge clk); w++; end
    end
    chk(claims == 1, "R2", "claim after line freed", claims, 1);
    chk(!lost, "R2", "lost after freed", lost, 0);
    @(negedge clk);
    check_data(1);

    // stalled transmit stream
    tx_plan = '{8'h96, 8'h01, 8'hF0, 8'h00};
    run_req(3, 5);
    check_data(3);

    // collision: peer wins first round
    collide_arm = 1;
    tx_plan = '{8'hC5, 8'h2B, 8'h00, 8'h00};
    run_req(2, 0);
    chk(losses == 1, "R4", "lost rounds", losses, 1);
    chk(claims == 2, "R4", "claims incl retry", claims, 2);
    chk(!got_lost, "R4", "lost flag after retry win", got_lost, 0);
    check_data(2);

    // chip-select held forever: give up
    peer_cs = 1;
    run_req(1, 0);
    chk(got_lost, "R5", "lost flag after all tries", got_lost, 1);
    chk(claims == TRIES, "R5", "claim attempts", claims, TRIES);
    chk(own_rises == 0, "R5", "bus enabled during lost run", own_rises, 0);
    chk(mosi_q.size() == 0, "R5", "bytes sent", mosi_q.size(), 0);
    peer_cs = 0;
    repeat (4) @(negedge clk);

    // zero-length request
    claims = 0;
    @(negedge clk); start = 1; nbytes = 8'd0;
    @(negedge clk); start = 0;
    chk(done && !lost, "R11", "immediate done", {done, lost}, 2);
    repeat (10) @(negedge clk);
    chk(claims == 0, "R11", "claims on zero length", claims, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule